// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A single-cycle enable, `tick16`, runs at sixteen times the bit rate and paces all of the receiver's timing. The serial input first passes through a two-flop synchronizer. While the receiver is idle it watches for a high-to-low edge on the input. It then confirms the start bit at the middle of its cell. After that it samples each data bit, the optional parity bit and the stop bit near the middle of its cell.

Each finished character moves from the shift register into a receive buffer. Four status bits report the condition of the line. Data-ready is cleared by a buffer read. The three error flags are cleared by a separate status read. The word length and the parity settings are captured when the start edge is accepted, so one character always uses a single set of settings.

Top module: `uart_rx_core`

## Requirements
- R1: The input is synchronized by two flops. On a `tick16` pulse while idle, a low input that was high at the previous tick starts a character. The start bit is sampled on the 8th tick after that. Every later bit is sampled 16 ticks after the one before it.
- R2: If the input is high at the start-bit sample, the edge is treated as noise. No character is produced and the receiver goes back to idle.
- R3: `lc_wlen` selects the data length: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. Data arrives least significant bit first. Buffer bits above the word length read 0.
- R4: When `lc_par_en` = 1, one parity bit follows the data. `lc_par_even` = 1 selects even parity and 0 selects odd parity. A mismatch sets `line_status[2]`.
- R5: `line_status[0]` (data ready) sets when a character is transferred to the buffer. A one-cycle `rbr_rd` pulse clears it. A transfer in the same cycle as `rbr_rd` leaves it set.
- R6: A transfer while data ready is set, with no `rbr_rd` in that cycle, sets `line_status[1]` (overrun). The new character still replaces the buffer contents.
- R7: A stop bit sampled low sets `line_status[3]` (framing error).
- R8: Overrun, parity and framing flags stay set until an `lsr_rd` pulse clears them. `lsr_rd` leaves data ready and the buffer unchanged. A flag set in the same cycle as `lsr_rd` stays set.
- R9: After the stop-bit sample the receiver is idle. A start edge on the next tick begins a new character, so characters with one stop bit can follow each other directly.
- R10: Line-control inputs are captured when the start edge is accepted. Changing them in the middle of a character has no effect on that character.
- R11: After reset, `line_status` and `rbr_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable at 16x the bit rate, one clock wide |
| rxd | input | 1 | Asynchronous serial input, idle high |
| lc_wlen | input | 2 | Word length code |
| lc_par_en | input | 1 | Parity enable |
| lc_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Status read strobe, clears error flags |
| rbr_data | output | 8 | Receive buffer contents |
| line_status | output | 4 | bit0 ready, bit1 overrun, bit2 parity error, bit3 framing error |

## Verification
The assertions check the status update rules on every cycle:
- a transfer sets data ready;
- a read clears it unless a transfer wins;
- overrun follows an unread transfer;
- a status read drops the error flags;
- a failed start check returns the receiver to idle.

Sampling position, bit order, word-length masking, parity polarity and latching of the line settings are shown only by the bench scenarios. These drive whole serial frames and compare the received buffer and flags with a reference model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    parameter int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
    } line_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int MIN_BITS = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_s,
    input  line_cfg_t cfg_in,
    output logic      xfer,
    output rx_char_t  char_out
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              prev;
        line_cfg_t         cfg;
        logic [DATA_W-1:0] shreg;
        logic              perr;
        logic              ferr;
        logic              done;
    } samp_t;

    samp_t q, d;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        last_idx = IDX_W'(q.cfg.wlen) + IDX_W'(MIN_BITS - 1);
        if (tick) begin
            d.prev = rx_s;
            case (q.st)
                ST_IDLE: begin
                    if (q.prev && !rx_s) begin
                        d.st    = ST_START;
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.cfg   = cfg_in;
                        d.shreg = '0;
                        d.perr  = 1'b0;
                        d.ferr  = 1'b0;
                    end
                end
                ST_START: begin
                    if (q.cnt == HALF_LAST) begin
                        d.cnt = '0;
                        d.st  = rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == FULL_LAST) begin
                        d.cnt            = '0;
                        d.shreg[q.idx]   = rx_s;
                        if (q.idx == last_idx)
                            d.st = q.cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == FULL_LAST) begin
                        d.cnt  = '0;
                        d.perr = q.cfg.par_even ? (^q.shreg ^ rx_s)
                                                : ~(^q.shreg ^ rx_s);
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == FULL_LAST) begin
                        d.cnt  = '0;
                        d.ferr = ~rx_s;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign xfer          = q.done;
    assign char_out.data = q.shreg;
    assign char_out.perr = q.perr;
    assign char_out.ferr = q.ferr;

    // R2: a start bit seen high at mid-cell is dropped without a character
    p_spike_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.st == ST_START && q.cnt == HALF_LAST && rx_s)
        |=> (q.st == ST_IDLE && !q.done));

    // R1: the start counter never passes the half-cell sample point
    p_start_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START) |-> (q.cnt <= HALF_LAST));

    // R9: a finished character leaves the receiver idle
    p_idle_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.st == ST_STOP && q.cnt == FULL_LAST) |=> (q.st == ST_IDLE && q.done));
endmodule

// File: rtl/rx_status.sv
module rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  rx_char_t          char_in,
    input  logic              rbr_rd,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rbr_data,
    output logic [3:0]        line_status
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              dr;
        logic              oe;
        logic              pe;
        logic              fe;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (rbr_rd) d.dr = 1'b0;
        if (lsr_rd) begin
            d.oe = 1'b0;
            d.pe = 1'b0;
            d.fe = 1'b0;
        end
        if (xfer) begin
            d.data = char_in.data;
            d.dr   = 1'b1;
            d.oe   = d.oe | (q.dr & ~rbr_rd);
            d.pe   = d.pe | char_in.perr;
            d.fe   = d.fe | char_in.ferr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rbr_data    = q.data;
    assign line_status = {q.fe, q.pe, q.oe, q.dr};

    p_ready_on_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> line_status[0]);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !xfer) |=> !line_status[0]);

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && line_status[0] && !rbr_rd) |=> line_status[1]);

    p_lsr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !xfer) |=> (line_status[3:1] == 3'b000));

    p_lsr_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !xfer && !rbr_rd) |=> ($stable(rbr_data) && $stable(line_status[0])));

    p_framing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && char_in.ferr) |=> line_status[3]);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        rxd,
    input  logic [1:0]  lc_wlen,
    input  logic        lc_par_en,
    input  logic        lc_par_even,
    input  logic        rbr_rd,
    input  logic        lsr_rd,
    output logic [7:0]  rbr_data,
    output logic [3:0]  line_status
);
    logic      rx_s;
    logic      xfer;
    rx_char_t  ch;
    line_cfg_t cfg;

    assign cfg.wlen     = lc_wlen;
    assign cfg.par_en   = lc_par_en;
    assign cfg.par_even = lc_par_even;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    rx_sampler #(.OVS(OVS), .MIN_BITS(5)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rx_s    (rx_s),
        .cfg_in  (cfg),
        .xfer    (xfer),
        .char_out(ch)
    );

    rx_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .char_in    (ch),
        .rbr_rd     (rbr_rd),
        .lsr_rd     (lsr_rd),
        .rbr_data   (rbr_data),
        .line_status(line_status)
    );
endmodule

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] lc_wlen = 2'b11;
    logic       lc_par_en = 1'b0;
    logic       lc_par_even = 1'b0;
    logic       rbr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rbr_data;
    logic [3:0] line_status;

    int n_checks = 0;
    int n_fail   = 0;
    int tdiv     = 0;

    logic [7:0] e_data = 8'h00;
    logic       e_dr = 0, e_oe = 0, e_pe = 0, e_fe = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .lc_wlen(lc_wlen), .lc_par_en(lc_par_en), .lc_par_even(lc_par_even),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
        .rbr_data(rbr_data), .line_status(line_status)
    );

    function automatic logic [7:0] wmask(input logic [1:0] wl);
        return 8'((16'd1 << (5 + wl)) - 1);
    endfunction

    function automatic logic par_bit(input logic [7:0] v, input logic even);
        return even ? ^v : ~(^v);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick16);
        end
        @(negedge clk);
    endtask

    task automatic check(input string req);
        logic [3:0] exp_ls;
        exp_ls = {e_fe, e_pe, e_oe, e_dr};
        n_checks++;
        if (line_status !== exp_ls || rbr_data !== e_data) begin
            n_fail++;
            $display("FAIL %s: status=%b data=%h expected status=%b data=%h",
                     req, line_status, rbr_data, exp_ls, e_data);
        end
    endtask

    task automatic pulse_rbr();
        @(negedge clk); rbr_rd = 1'b1;
        @(negedge clk); rbr_rd = 1'b0;
        e_dr = 1'b0;
    endtask

    task automatic pulse_lsr();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
        e_oe = 1'b0; e_pe = 1'b0; e_fe = 1'b0;
    endtask

    // Send a frame; mid_wl/mid_pe change line control after the start cell (R10)
    task automatic send_char(input logic [7:0] d, input logic [1:0] wl,
                             input logic pen, input logic even,
                             input logic bad_par, input logic bad_stop,
                             input logic [1:0] mid_wl, input logic mid_pe,
                             input int gap);
        logic [7:0] m;
        logic pb;
        m = d & wmask(wl);
        pb = par_bit(m, even) ^ bad_par;
        lc_wlen = wl; lc_par_en = pen; lc_par_even = even;
        rxd = 1'b0;
        wait_ticks(16);
        lc_wlen = mid_wl; lc_par_en = mid_pe;
        for (int b = 0; b < 5 + int'(wl); b++) begin
            rxd = d[b];
            wait_ticks(16);
        end
        if (pen) begin
            rxd = pb;
            wait_ticks(16);
        end
        rxd = ~bad_stop;
        wait_ticks(16);
        rxd = 1'b1;
        e_oe = e_oe | e_dr;
        e_dr = 1'b1;
        e_data = m;
        e_pe = e_pe | (pen & bad_par);
        e_fe = e_fe | bad_stop;
        wait_ticks(gap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: status=%b data=%h expected completion", line_status, rbr_data);
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_ticks(4);
        check("R11 reset");

        // R1/R3: 8-bit, no parity, LSB first
        send_char(8'hA5, 2'b11, 0, 0, 0, 0, 2'b11, 0, 8);
        check("R1 R3 8-bit frame");
        pulse_rbr();
        check("R5 read clears ready");

        // R2: short low spike ignored
        rxd = 1'b0; wait_ticks(5); rxd = 1'b1; wait_ticks(40);
        check("R2 noise spike");

        // R3: 5-bit word masks upper bits
        send_char(8'hFF, 2'b00, 0, 0, 0, 0, 2'b00, 0, 8);
        check("R3 5-bit mask");
        pulse_rbr();

        // R4: even and odd parity good, then bad
        send_char(8'h3C, 2'b11, 1, 1, 0, 0, 2'b11, 1, 8);
        check("R4 even parity ok");
        pulse_rbr();
        send_char(8'h07, 2'b10, 1, 0, 0, 0, 2'b10, 1, 8);
        check("R4 odd parity ok");
        pulse_rbr();
        send_char(8'h51, 2'b11, 1, 0, 1, 0, 2'b11, 1, 8);
        check("R4 odd parity error");
        pulse_lsr();
        check("R8 status read clears parity");
        pulse_rbr();

        // R7: framing error
        send_char(8'h99, 2'b11, 0, 0, 0, 1, 2'b11, 0, 8);
        check("R7 framing");
        pulse_rbr();
        check("R8 framing sticky after buffer read");
        pulse_lsr();
        check("R8 framing cleared");

        // R6/R9: back-to-back with no gap, no read -> overrun, newest kept
        send_char(8'h12, 2'b11, 0, 0, 0, 0, 2'b11, 0, 0);
        send_char(8'h34, 2'b11, 0, 0, 0, 0, 2'b11, 0, 8);
        check("R6 R9 overrun back-to-back");
        pulse_lsr();
        check("R8 overrun cleared, ready kept");
        pulse_rbr();

        // R10: change line control mid-character
        send_char(8'hC3, 2'b11, 0, 0, 0, 0, 2'b00, 1, 8);
        check("R10 latched config");
        pulse_rbr();

        // Random frames
        for (int it = 0; it < 30; it++) begin
            logic [7:0] dv;
            logic [1:0] wl;
            logic pen, ev, bp, bs;
            dv = 8'($urandom);
            wl = 2'($urandom);
            pen = 1'($urandom);
            ev = 1'($urandom);
            bp = pen & ($urandom % 5 == 0);
            bs = ($urandom % 6 == 0);
            if ($urandom % 2 == 0) begin
                pulse_rbr();
                check("R5 random read");
            end
            if ($urandom % 4 == 0) begin
                pulse_lsr();
                check("R8 random status read");
            end
            send_char(dv, wl, pen, ev, bp, bs, wl, pen, 2 + int'($urandom % 20));
            check("R3 R4 R6 R7 random frame");
        end
        summary();
    end
endmodule